// File: doc/BRIEF.md
# Console Transmit Register Stub

This block is a minimal console output port for a processor subsystem. It presents a small register set laid out the way common 16550-family drivers expect, on a simple 32-bit memory-mapped slave bus. Software writes characters to a data register, and each accepted write becomes a one-cycle valid strobe carrying the byte on a transmit output. A simulation console or a downstream serializer can consume that strobe.

There is no baud generator, no framing, no receive path and no interrupt logic. The status registers return constants, so a polling driver always sees the transmitter ready and never stalls. The line control register keeps one bit, the divisor-latch access bit. While that bit is set, writes to the data register are treated as divisor programming and discarded. Every access completes in the cycle it is presented.

Top module: `con_tx_stub`

## Requirements
- R1: After reset the divisor-latch bit is clear and `tx_valid` is low.
- R2: A write to offset 0x00 while the divisor-latch bit is clear raises `tx_valid` for exactly one cycle, in the cycle after the write. In that cycle `tx_data` equals bits [7:0] of the write data.
- R3: A write to offset 0x00 while the divisor-latch bit is set produces no `tx_valid` pulse.
- R4: A write to offset 0x0C loads the divisor-latch bit from bit 7 of the write data, and ignores all other bits.
- R5: A read of offset 0x10 returns 0x00000003.
- R6: A read of offset 0x14 returns 0x00000060 (holding register empty, bit 5; transmitter idle, bit 6).
- R7: A read of any other offset, including 0x00 and 0x0C, returns zero.
- R8: A write to any offset other than 0x00 and 0x0C leaves the divisor-latch bit unchanged and produces no `tx_valid` pulse.
- R9: Decoding uses only address bits [7:0]. Upper address bits do not change which register is selected.
- R10: Data writes in consecutive cycles produce `tx_valid` pulses in consecutive cycles, each carrying its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| tx_valid | output | 1 | One-cycle character strobe |
| tx_data | output | 8 | Character byte |

## Verification
Two things can happen in the same cycle: a `tx_valid` pulse from the previous cycle's data write, and a line-control write that sets the divisor-latch bit. The bench issues a data write and then, in the very next cycle, a write of 0x80 to offset 0x0C. It checks that the pulse still appears with the first byte, because the gate is judged when the write is accepted. It then checks that a data write issued afterwards is suppressed. A status read is also placed in a cycle where a pulse is live, to show that the read value stays constant during transmission.

// File: rtl/con_tx_pkg.sv
package con_tx_pkg;
    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_LCTL = 8'h0C;
    localparam logic [7:0] OFS_MCTL = 8'h10;
    localparam logic [7:0] OFS_LSTS = 8'h14;
    localparam logic [7:0] VAL_MCTL = 8'h03;
    localparam logic [7:0] VAL_LSTS = 8'h60;
    localparam int         LATCH_BIT = 7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_LCTL,
        SEL_MCTL,
        SEL_LSTS
    } reg_sel_e;

    typedef struct packed {
        logic       latch;
        logic       tx_vld;
        logic [7:0] tx_byte;
    } tx_state_t;
endpackage

// File: rtl/con_tx_decode.sv
module con_tx_decode
    import con_tx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int OFS_W = 8;

    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs = addr[OFS_W-1:0];
        unique case (ofs)
            OFS_DATA: sel = SEL_DATA;
            OFS_LCTL: sel = SEL_LCTL;
            OFS_MCTL: sel = SEL_MCTL;
            OFS_LSTS: sel = SEL_LSTS;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/con_tx_core.sv
module con_tx_core
    import con_tx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = 1'b0;
        if (wr) begin
            if (sel == SEL_LCTL) begin
                st_d.latch = wdata[LATCH_BIT];
            end
            if (sel == SEL_DATA && !st_q.latch) begin
                st_d.tx_vld  = 1'b1;
                st_d.tx_byte = wdata[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.tx_vld;
    assign tx_data  = st_q.tx_byte;

    p_pulse_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(wr && sel == SEL_DATA));
    p_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA && !st_q.latch) |=> (tx_valid && tx_data == $past(wdata[7:0])));
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DATA && st_q.latch) |=> !tx_valid);
    p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_LCTL) |=> (st_q.latch == $past(wdata[LATCH_BIT])));
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_LCTL) |=> $stable(st_q.latch));
endmodule

// File: rtl/con_tx_rdmux.sv
module con_tx_rdmux
    import con_tx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              rd,
    input  reg_sel_e          sel,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_MCTL: rdata[7:0] = VAL_MCTL;
                SEL_LSTS: rdata[7:0] = VAL_LSTS;
                default:  rdata      = '0;
            endcase
        end
    end
endmodule

// File: rtl/con_tx_stub.sv
module con_tx_stub
    import con_tx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data
);
    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;

    assign wr_en = bus_en && bus_we;
    assign rd_en = bus_en && !bus_we;

    con_tx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    con_tx_core #(.DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en),
        .sel      (sel),
        .wdata    (bus_wdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    con_tx_rdmux #(.DATA_W(DATA_W)) u_rd (
        .rd    (rd_en),
        .sel   (sel),
        .rdata (bus_rdata)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !tx_valid);
    p_lsts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr[7:0] == OFS_LSTS) |-> bus_rdata == DATA_W'(VAL_LSTS));
    p_mctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr[7:0] == OFS_MCTL) |-> bus_rdata == DATA_W'(VAL_MCTL));
    p_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr[7:0] != OFS_MCTL && bus_addr[7:0] != OFS_LSTS) |-> bus_rdata == '0);
    p_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr[7:0] != OFS_DATA) |=> !tx_valid);
endmodule

// File: tb/sim_con_tx_stub.sv
module sim_con_tx_stub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    con_tx_stub u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a write at a negedge; returns at the next negedge, when the strobe is visible.
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
        bus_write(16'h0000, 32'h55);
        chk("R1 latch clear after reset", {31'b0, tx_valid}, 32'h1);
    endtask

    task automatic t_plain_tx();
        bus_write(16'h0000, 32'hDEAD_BE48);
        chk("R2 strobe", {31'b0, tx_valid}, 32'h1);
        chk("R2 byte", {24'b0, tx_data}, 32'h48);
        @(negedge clk);
        chk("R2 single cycle", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_latch_gate();
        bus_write(16'h000C, 32'h80);
        bus_write(16'h0000, 32'h31);
        chk("R3 blocked", {31'b0, tx_valid}, 32'h0);
        bus_write(16'h000C, 32'hFFFF_FF7F);
        bus_write(16'h0000, 32'h32);
        chk("R4 bit7 clears", {31'b0, tx_valid}, 32'h1);
        bus_write(16'h000C, 32'h0000_0080);
        bus_write(16'h0000, 32'h33);
        chk("R4 bit7 sets", {31'b0, tx_valid}, 32'h0);
        bus_write(16'h000C, 32'h7F);
        bus_write(16'h0000, 32'h34);
        chk("R4 low bits ignored", {31'b0, tx_valid}, 32'h1);
    endtask

    task automatic t_reads();
        logic [31:0] d;
        bus_read(16'h0010, d); chk("R5 mctl", d, 32'h3);
        bus_read(16'h0014, d); chk("R6 lsts", d, 32'h60);
        bus_read(16'h0000, d); chk("R7 data reads zero", d, 32'h0);
        bus_read(16'h000C, d); chk("R7 lctl reads zero", d, 32'h0);
        bus_read(16'h0018, d); chk("R7 other", d, 32'h0);
        bus_read(16'h0011, d); chk("R7 misaligned", d, 32'h0);
    endtask

    task automatic t_other_writes();
        bus_write(16'h0010, 32'hFFFF_FFFF);
        chk("R8 no strobe", {31'b0, tx_valid}, 32'h0);
        bus_write(16'h0008, 32'h80);
        bus_write(16'h0000, 32'h41);
        chk("R8 latch untouched", {31'b0, tx_valid}, 32'h1);
        bus_write(16'h000D, 32'h80);
        bus_write(16'h0000, 32'h42);
        chk("R8 near-miss offset", {31'b0, tx_valid}, 32'h1);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        bus_write(16'h1200, 32'h5A);
        chk("R9 upper bits strobe", {31'b0, tx_valid}, 32'h1);
        chk("R9 upper bits byte", {24'b0, tx_data}, 32'h5A);
        bus_read(16'hAB14, d); chk("R9 upper bits read", d, 32'h60);
    endtask

    task automatic t_back2back();
        bus_write(16'h0000, 32'h61);
        chk("R10 first", {23'b0, tx_valid, tx_data}, 32'h161);
        bus_write(16'h0000, 32'h62);
        chk("R10 second", {23'b0, tx_valid, tx_data}, 32'h162);
        bus_write(16'h0000, 32'h63);
        chk("R10 third", {23'b0, tx_valid, tx_data}, 32'h163);
    endtask

    task automatic t_overlap();
        logic [31:0] d;
        bus_write(16'h0000, 32'h70);
        chk("R2 pulse live", {23'b0, tx_valid, tx_data}, 32'h170);
        bus_write(16'h000C, 32'h80);
        chk("R3 no pulse from lctl", {31'b0, tx_valid}, 32'h0);
        bus_write(16'h0000, 32'h71);
        chk("R3 blocked after overlap", {31'b0, tx_valid}, 32'h0);
        bus_write(16'h000C, 32'h00);
        bus_write(16'h0000, 32'h72);
        bus_read(16'h0014, d);
        chk("R6 read during pulse", d, 32'h60);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_tx();
        t_latch_gate();
        t_reads();
        t_other_writes();
        t_alias();
        t_back2back();
        t_overlap();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule